// File: doc/BRIEF.md
# Audio Transmit Holding Buffer with Underrun Status

This block sits between a host bus and a serial audio shifter. The host writes one sample word at a time into a single-word holding register. The shifter pulses `word_req` each time it starts a new slot, and the word it takes appears on `tx_word` one clock later. If the host has written nothing since the last request, the request is an underrun. In that case the block repeats the word it sent last, and it keeps repeating that word until the host supplies new data.

A 32-bit status register records underruns in a sticky flag. The host can clear the flag but cannot set it. The register also holds an interrupt enable bit, the current channel slot and a frame-parity bit. `irq` is high while both the flag and the enable are 1.

A three-state controller tracks the buffer. The states are `TX_IDLE` (no fresh word; the last one was consumed), `TX_LOADED` (a fresh word is waiting) and `TX_STALE` (an underrun happened and the old word is being repeated). The transitions are:
- IDLE to LOADED on a host write.
- IDLE to STALE on a request with no write.
- LOADED stays LOADED on a write, with or without a request.
- LOADED to IDLE on a request with no write.
- STALE to LOADED on a host write.
- STALE stays STALE on a request.
- Reset enters IDLE.

Top module: `aud_tx_holdbuf`

## Requirements
- R1: After reset, `tx_word`, `irq` and every bit of `st_rd_data` are 0.
- R2: When a word was written after the previous request, the next request places that word on `tx_word` in the following cycle and leaves the underrun flag (bit 29) unchanged.
- R3: A request with no write since the previous request sets bit 29 one cycle later, and `tx_word` keeps the previously sent word.
- R4: Bit 29 is set by an underrun whatever the value of the enable bit (bit 28).
- R5: A status write with bit 29 = 0 clears the flag, and a status write with bit 29 = 1 leaves it unchanged. If an underrun occurs in the same cycle as a clearing write, the flag ends up 1.
- R6: `irq` is 1 exactly when bit 29 and bit 28 of the status register are both 1.
- R7: Every status write loads bit 28 from `st_wr_data[28]`.
- R8: The channel field `st_rd_data[5:4]` advances by one on every request, including underruns. After the value `chan_last` it wraps to 0, and at each wrap bit 3 (frame parity) toggles. Without a request, both fields hold their values.
- R9: If a host write and a request fall in the same cycle, the request takes the old word, and the new word is delivered by the next request without an underrun.
- R10: Bits 31:30, 27:6 and 2:0 of `st_rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for a sample word |
| wr_data | input | DATA_W | Sample word from the host |
| st_wr_en | input | 1 | Host write strobe for the status register |
| st_wr_data | input | 32 | Status write data (bit 29 = 0 clears the flag, bit 28 = enable) |
| st_rd_data | output | 32 | Status readback |
| chan_last | input | CHAN_W | Highest channel number (channel count minus 1) |
| word_req | input | 1 | Shifter pulse requesting the next word |
| tx_word | output | DATA_W | Word handed to the shifter |
| irq | output | 1 | Underrun interrupt |

## Verification
The hardest cases to reach are the collisions: a request and a host write in the same cycle, and an underrun in the same cycle as a clearing status write. Both depend on which update wins inside one edge. The stimulus drives each collision deliberately from a single step that raises both strobes together. It then follows up with a plain request, to show that the colliding write was neither lost nor counted as stale. A second reset with a larger `chan_last` covers the four-slot wrap and the parity toggle during a run of back-to-back underruns.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_LOADED = 2'd1,
        TX_STALE  = 2'd2
    } txbuf_state_e;

    localparam int STAT_W    = 32;
    localparam int FLAG_BIT  = 29;
    localparam int EN_BIT    = 28;
    localparam int SWORD_BIT = 3;
    localparam int CHAN_LSB  = 4;
endpackage

// File: rtl/aud_tx_fsm.sv
module aud_tx_fsm
    import aud_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic word_req,
    output logic fresh,
    output logic uflow
);
    txbuf_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (wr_en)         state_d = TX_LOADED;
                else if (word_req) state_d = TX_STALE;
            end
            TX_LOADED: begin
                if (wr_en)         state_d = TX_LOADED;
                else if (word_req) state_d = TX_IDLE;
            end
            TX_STALE: begin
                if (wr_en)         state_d = TX_LOADED;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fresh = (state_q == TX_LOADED);
        uflow = word_req && (state_q != TX_LOADED);
    end
endmodule

// File: rtl/aud_tx_slot_ctr.sv
module aud_tx_slot_ctr #(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [CHAN_W-1:0] last,
    output logic [CHAN_W-1:0] chan,
    output logic              sword
);
    logic wrap;
    assign wrap = (chan >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan  <= '0;
            sword <= 1'b0;
        end else if (step) begin
            if (wrap) begin
                chan  <= '0;
                sword <= ~sword;
            end else begin
                chan  <= chan + 1'b1;
            end
        end
    end
endmodule

// File: rtl/aud_tx_status.sv
module aud_tx_status
    import aud_tx_pkg::*;
#(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uflow,
    input  logic              st_wr_en,
    input  logic [STAT_W-1:0] st_wr_data,
    input  logic [CHAN_W-1:0] chan,
    input  logic              sword,
    output logic [STAT_W-1:0] st_rd_data,
    output logic              irq
);
    logic flag_q, en_q;
    logic unused_wr_bits;
    assign unused_wr_bits = ^{st_wr_data[STAT_W-1:FLAG_BIT+1], st_wr_data[EN_BIT-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (st_wr_en) en_q <= st_wr_data[EN_BIT];
            if (uflow)
                flag_q <= 1'b1;
            else if (st_wr_en && !st_wr_data[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        st_rd_data = '0;
        st_rd_data[FLAG_BIT]             = flag_q;
        st_rd_data[EN_BIT]               = en_q;
        st_rd_data[SWORD_BIT]            = sword;
        st_rd_data[CHAN_LSB +: CHAN_W]   = chan;
        irq = flag_q & en_q;
    end
endmodule

// File: rtl/aud_tx_holdbuf.sv
module aud_tx_holdbuf
    import aud_tx_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              st_wr_en,
    input  logic [STAT_W-1:0] st_wr_data,
    output logic [STAT_W-1:0] st_rd_data,
    input  logic [CHAN_W-1:0] chan_last,
    input  logic              word_req,
    output logic [DATA_W-1:0] tx_word,
    output logic              irq
);
    logic              fresh, uflow, sword;
    logic [CHAN_W-1:0] chan;
    logic [DATA_W-1:0] hold_q;

    aud_tx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_req(word_req),
        .fresh(fresh), .uflow(uflow)
    );

    aud_tx_slot_ctr #(.CHAN_W(CHAN_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .step(word_req), .last(chan_last),
        .chan(chan), .sword(sword)
    );

    aud_tx_status #(.CHAN_W(CHAN_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .uflow(uflow), .st_wr_en(st_wr_en),
        .st_wr_data(st_wr_data), .chan(chan), .sword(sword),
        .st_rd_data(st_rd_data), .irq(irq)
    );

    // holding register and the word handed to the shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            tx_word <= '0;
        end else begin
            if (word_req) tx_word <= hold_q;
            if (wr_en)    hold_q  <= wr_data;
        end
    end
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
    parameter int DATA_W = 24,
    parameter int CHAN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_req,
    input logic              st_wr_en,
    input logic [31:0]       st_wr_data,
    input logic [31:0]       st_rd_data,
    input logic [CHAN_W-1:0] chan_last,
    input logic [DATA_W-1:0] tx_word,
    input logic              irq,
    input logic              fresh
);
    assert_uflow_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && !fresh) |=> st_rd_data[29]);

    assert_repeat_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && !fresh) |=> $stable(tx_word));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd_data[29] && !(st_wr_en && !st_wr_data[29])) |=> st_rd_data[29]);

    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && !st_wr_data[29] && !(word_req && !fresh)) |=> !st_rd_data[29]);

    assert_irq_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (st_rd_data[29] && st_rd_data[28]));

    assert_en_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |=> (st_rd_data[28] == $past(st_wr_data[28])));

    assert_chan_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && (st_rd_data[5:4] < chan_last)) |=>
            (st_rd_data[5:4] == $past(st_rd_data[5:4]) + 2'd1));

    assert_chan_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_req |=> $stable(st_rd_data[5:3]));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd_data[31:30] == 2'b00) && (st_rd_data[27:6] == '0) && (st_rd_data[2:0] == 3'b000));
endmodule

bind aud_tx_holdbuf aud_tx_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_req(word_req), .st_wr_en(st_wr_en),
    .st_wr_data(st_wr_data), .st_rd_data(st_rd_data), .chan_last(chan_last),
    .tx_word(tx_word), .irq(irq), .fresh(fresh)
);

// File: tb/tb_aud_tx_holdbuf.sv
`timescale 1ns/1ps
module tb_aud_tx_holdbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic        st_wr_en = 1'b0;
    logic [31:0] st_wr_data = '0;
    logic [31:0] st_rd_data;
    logic [1:0]  chan_last = 2'd1;
    logic        word_req = 1'b0;
    logic [23:0] tx_word;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    aud_tx_holdbuf dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .st_rd_data(st_rd_data),
        .chan_last(chan_last), .word_req(word_req), .tx_word(tx_word), .irq(irq)
    );

    // behavioural reference
    bit          m_valid, m_flag, m_en, m_sw, m_uf;
    logic [23:0] m_hold, m_out;
    int          m_chan;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_flag = 0; m_en = 0; m_sw = 0;
            m_hold = '0; m_out = '0; m_chan = 0;
        end else begin
            m_uf = word_req && !m_valid;
            if (word_req) begin
                m_out = m_hold;
                if (m_chan >= int'(chan_last)) begin m_chan = 0; m_sw = !m_sw; end
                else m_chan = m_chan + 1;
            end
            if (wr_en) begin m_hold = wr_data; m_valid = 1; end
            else if (word_req) m_valid = 0;
            if (st_wr_en) begin
                m_en = st_wr_data[28];
                if (!st_wr_data[29]) m_flag = 0;
            end
            if (m_uf) m_flag = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0]  mc;
            logic [31:0] exp_st;
            mc = m_chan[1:0];
            exp_st = {2'b00, m_flag, m_en, 22'd0, mc, m_sw, 3'b000};
            chk("R2 model tx_word", {8'd0, tx_word}, {8'd0, m_out});
            chk("R6 model irq", {31'd0, irq}, {31'd0, m_flag & m_en});
            chk("R8 model status", st_rd_data, exp_st);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input logic w, input logic [23:0] d, input logic r,
                        input logic s, input logic [31:0] sd);
        @(negedge clk);
        wr_en = w; wr_data = d; word_req = r; st_wr_en = s; st_wr_data = sd;
        @(negedge clk);
        wr_en = 0; word_req = 0; st_wr_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        chk("R1 tx_word", {8'd0, tx_word}, 32'd0);
        chk("R1 status", st_rd_data, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        step(1, 24'hA5A5A5, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R2 word delivered", {8'd0, tx_word}, 32'h00A5A5A5);
        chk("R2 no flag", st_rd_data, 32'h0000_0010);

        step(0, 0, 1, 0, 0);
        chk("R3 word repeated", {8'd0, tx_word}, 32'h00A5A5A5);
        chk("R4 flag with enable 0", st_rd_data, 32'h2000_0008);
        chk("R4 irq stays low", {31'd0, irq}, 32'd0);
        chk("R8 wrap and parity", {26'd0, st_rd_data[5:0]}, 32'h08);

        step(0, 0, 0, 1, 32'h2000_0000);
        chk("R5 write 1 ignored", st_rd_data, 32'h2000_0008);

        step(0, 0, 0, 1, 32'h3000_0000);
        chk("R7 enable loaded", st_rd_data, 32'h3000_0008);
        chk("R6 irq high", {31'd0, irq}, 32'd1);

        step(0, 0, 0, 1, 32'h1000_0000);
        chk("R5 write 0 clears", st_rd_data, 32'h1000_0008);
        chk("R6 irq low", {31'd0, irq}, 32'd0);

        step(1, 24'h123456, 0, 0, 0);
        step(1, 24'h0BCDEF, 1, 0, 0);
        chk("R9 old word taken", {8'd0, tx_word}, 32'h00123456);
        step(0, 0, 1, 0, 0);
        chk("R9 new word next", {8'd0, tx_word}, 32'h000BCDEF);
        chk("R9 no underrun", st_rd_data, 32'h1000_0000);

        step(0, 0, 1, 1, 32'h0000_0000);
        chk("R5 set beats clear", st_rd_data, 32'h2000_0010);
        chk("R3 repeat after consume", {8'd0, tx_word}, 32'h000BCDEF);

        step(0, 0, 0, 1, 32'hFFFF_FFFF);
        chk("R10 reserved zero", st_rd_data, 32'h3000_0010);
        chk("R6 irq with both", {31'd0, irq}, 32'd1);

        chan_last = 2'd3;
        do_reset();
        chk("R1 second reset", st_rd_data, 32'd0);
        for (int i = 1; i <= 4; i++) begin
            step(0, 0, 1, 0, 0);
            chk("R8 four-slot count", {30'd0, st_rd_data[5:4]}, i % 4);
        end
        chk("R8 parity after wrap", {31'd0, st_rd_data[3]}, 32'd1);
        chk("R4 flag from run", {31'd0, st_rd_data[29]}, 32'd1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule